// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave side of a serial memory's SPI port. It handles clock modes 0 and 3. It takes in an instruction byte, a three-byte address and data bytes, all most significant bit first. It decodes the command set and sends read data back from a byte-wide storage port. Write data bytes go to a staging strobe along with their address. A single commit strobe is raised only when the command ends cleanly on a byte boundary. The cell timing, the write-enable flag, the status contents and protection policy all sit outside the block. They reach it as a busy input, a status byte, a lock flag and request strobes.

All four SPI pins are synchronized into one fast system clock, and their edges are detected there. The serial clock must therefore run at well under a quarter of the system clock. A hold input pauses a transfer without losing its place. An unknown opcode parks the engine until deselect. After reset the engine stays deaf until it has seen a falling edge on chip select.

Top module: `spi_mem_fe`

## Requirements
- R1: After reset the output enable is low and no strobe fires. A chip select that is already low at reset starts no command: bytes clocked before the first falling edge of chip select are ignored.
- R2: Opcode 06h raises `wen_set_o` and 04h raises `wen_clr_o`, each for one cycle. This happens only when chip select rises after exactly 8 clock rises. Any extra clock cancels it.
- R3: Opcode 03h followed by a 3-byte address streams storage bytes. Only the low 19 address bits are used. Each bit is shifted out on a falling clock edge, and the address steps by one per byte, wrapping from 7FFFFh to 0.
- R4: Data is sampled on rising clock edges whether the clock idles low (mode 0) or high (mode 3).
- R5: With opcode 02h, each complete data byte pulses `stage_we_o` with the byte and the current `addr_o`. Between bytes only the low log2(PAGE_BYTES) address bits advance, so they wrap inside the page.
- R6: A write-type command pulses `commit_o` only if chip select rises after the 8th bit of at least one data byte and before another clock rise. Any other deselect discards it.
- R7: Any opcode outside the set {06h, 04h, 05h, 01h, 03h, 02h, 83h, 82h} makes the engine ignore the bus until deselect. The output stays disabled and later bytes cause no strobe.
- R8: Hold starts when `hold_ni` is low while the clock is low, and ends when it is high while the clock is low. During hold the output enable is low and clock edges are ignored.
- R9: Deselecting during hold clears the command state. The next command decodes normally.
- R10: While `busy_i` is high, 03h, 83h, 02h, 82h and 01h are rejected: no output and no commit. Opcode 05h is always accepted and repeats `status_i` for every byte.
- R11: Opcode 83h with address bit 10 clear reads storage with `id_sel_o` high. With bit 10 set, it repeats the byte {7'b0, lock_i} with no address step.
- R12: `commit_kind_o` encodes the committed command: 0 for 02h, 1 for 01h, 2 for 82h with address bit 10 clear, and 3 for 82h with bit 10 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Serial data out enable |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte to stream |
| lock_i | input | 1 | Identification page lock flag |
| addr_o | output | ADDR_W | Storage address for reads and staging |
| id_sel_o | output | 1 | Address targets the identification page |
| rdata_i | input | 8 | Storage read data for `addr_o` |
| stage_we_o | output | 1 | Data byte staging strobe |
| stage_data_o | output | 8 | Staged data byte |
| wen_set_o | output | 1 | Write-enable set request |
| wen_clr_o | output | 1 | Write-enable clear request |
| commit_o | output | 1 | Write commit strobe |
| commit_kind_o | output | 2 | Committed command kind |

## Verification
A bit counter that drifts by one shows up as a staged byte that is rotated by one bit, or as a commit that never arrives. It surfaces at the first `stage_we_o` or at the deselect. A wrong address register shows in the very next read byte or staging address, so wrap faults appear within two bytes of the page or array end. A hold or park state that fails to block clock edges corrupts the byte in progress, and the next read or staged value exposes it. A stale arming or command state after deselect turns into a spurious or missing strobe on the following command.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDID  = 8'h83;
  localparam logic [7:0] OP_WRID  = 8'h82;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_RSTS, ST_WDAT, ST_WAIT, ST_PARK
  } st_e;

  typedef enum logic [2:0] {
    CM_NONE, CM_WREN, CM_WRDI, CM_WSR, CM_RD, CM_WR, CM_RID, CM_WID
  } cmd_e;

  typedef enum logic [1:0] {
    CK_ARRAY = 2'd0, CK_STATUS = 2'd1, CK_ID = 2'd2, CK_LOCK = 2'd3
  } ck_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[g]}};
      else         ff <= {ff[0], in_i[g]};
    end
    assign lvl_o[g] = ff[1];
  end
endmodule

// File: rtl/sfe_hold.sv
module sfe_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sck_i,
  input  logic hold_ni,
  output logic held_o
);
  // hold state only moves while the serial clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_o <= 1'b0;
    else if (!sel_i) held_o <= 1'b0;
    else if (!sck_i) held_o <= !hold_ni;
  end
endmodule

// File: rtl/spi_mem_fe.sv
module spi_mem_fe
  import sfe_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic              lock_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              id_sel_o,
  input  logic [7:0]        rdata_i,
  output logic              stage_we_o,
  output logic [7:0]        stage_data_o,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              commit_o,
  output logic [1:0]        commit_kind_o
);
  localparam int PAW  = $clog2(PAGE_BYTES);
  localparam int KEEP = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ONE_A = 1;

  logic [3:0] lvl;
  logic cs_l, sck_l, mosi_l, hold_l, cs_q, sck_q;
  logic cs_fall, cs_rise, sck_r, sck_f;
  logic armed_q, sel, held, act;

  sfe_sync #(.N(4), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({hold_ni, mosi_i, sck_i, cs_ni}),
    .lvl_o (lvl)
  );
  assign {hold_l, mosi_l, sck_l, cs_l} = lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_l;
      sck_q <= sck_l;
    end
  end
  assign cs_fall = cs_q & ~cs_l;
  assign cs_rise = ~cs_q & cs_l;
  assign sck_r   = ~sck_q & sck_l;
  assign sck_f   = sck_q & ~sck_l;
  assign sel     = armed_q & ~cs_l;

  sfe_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .sck_i  (sck_l),
    .hold_ni(hold_l),
    .held_o (held)
  );
  assign act = sel & ~held;

  st_e  st_q;
  cmd_e cmd_q;
  ck_e  kind_q, kind_c;
  logic [2:0] bcnt_q, tcnt_q;
  logic [1:0] acnt_q;
  logic [6:0] sh_q;
  logic [7:0] tx_q, rx_byte, nxt_byte, stage_data_q;
  logic [ADDR_W-1:0] addr_q;
  logic have_dat_q, extra_q, lock_sel_q;
  logic stage_we_q, wen_set_q, wen_clr_q, commit_q;
  logic byte_end, rd_st, rd_cmd, page_adv;

  assign rx_byte  = {sh_q, mosi_l};
  assign byte_end = (bcnt_q == 3'd7);
  assign rd_st    = (st_q == ST_RDAT) || (st_q == ST_RSTS);
  assign rd_cmd   = (cmd_q == CM_RD) || (cmd_q == CM_RID);
  assign page_adv = (cmd_q == CM_WR) || ((cmd_q == CM_WID) && !lock_sel_q);
  assign nxt_byte = (st_q == ST_RSTS) ? status_i :
                    ((cmd_q == CM_RID) && lock_sel_q) ? {7'b0, lock_i} : rdata_i;

  always_comb begin
    case (cmd_q)
      CM_WSR:  kind_c = CK_STATUS;
      CM_WID:  kind_c = lock_sel_q ? CK_LOCK : CK_ID;
      default: kind_c = CK_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0; st_q <= ST_IDLE; cmd_q <= CM_NONE; kind_q <= CK_ARRAY;
      bcnt_q <= '0; tcnt_q <= '0; acnt_q <= '0; sh_q <= '0; tx_q <= '0;
      addr_q <= '0; stage_data_q <= '0;
      have_dat_q <= 1'b0; extra_q <= 1'b0; lock_sel_q <= 1'b0;
      stage_we_q <= 1'b0; wen_set_q <= 1'b0; wen_clr_q <= 1'b0; commit_q <= 1'b0;
    end else begin
      stage_we_q <= 1'b0;
      wen_set_q  <= 1'b0;
      wen_clr_q  <= 1'b0;
      commit_q   <= 1'b0;
      if (stage_we_q && page_adv) addr_q[PAW-1:0] <= addr_q[PAW-1:0] + PAW'(1);
      if (cs_fall) begin
        armed_q <= 1'b1; st_q <= ST_OPC; cmd_q <= CM_NONE;
        bcnt_q <= '0; acnt_q <= '0; have_dat_q <= 1'b0; extra_q <= 1'b0;
      end else if (cs_rise) begin
        if (st_q == ST_WAIT && !extra_q && bcnt_q == 3'd0) begin
          wen_set_q <= (cmd_q == CM_WREN);
          wen_clr_q <= (cmd_q == CM_WRDI);
        end
        if (st_q == ST_WDAT && have_dat_q && bcnt_q == 3'd0) begin
          commit_q <= 1'b1;
          kind_q   <= kind_c;
        end
        st_q <= ST_IDLE;
      end else if (act && sck_r) begin
        bcnt_q <= bcnt_q + 3'd1;
        sh_q   <= {sh_q[5:0], mosi_l};
        case (st_q)
          ST_OPC: if (byte_end) begin
            tcnt_q <= '0;
            acnt_q <= '0;
            case (rx_byte)
              OP_WREN:  begin cmd_q <= CM_WREN; st_q <= ST_WAIT; end
              OP_WRDI:  begin cmd_q <= CM_WRDI; st_q <= ST_WAIT; end
              OP_RDSR:  st_q <= ST_RSTS;
              OP_WRSR:  begin cmd_q <= CM_WSR; st_q <= busy_i ? ST_PARK : ST_WDAT; end
              OP_READ:  begin cmd_q <= CM_RD;  st_q <= busy_i ? ST_PARK : ST_ADDR; end
              OP_WRITE: begin cmd_q <= CM_WR;  st_q <= busy_i ? ST_PARK : ST_ADDR; end
              OP_RDID:  begin cmd_q <= CM_RID; st_q <= busy_i ? ST_PARK : ST_ADDR; end
              OP_WRID:  begin cmd_q <= CM_WID; st_q <= busy_i ? ST_PARK : ST_ADDR; end
              default:  st_q <= ST_PARK;
            endcase
          end
          ST_ADDR: if (byte_end) begin
            addr_q <= {addr_q[KEEP-1:0], rx_byte};
            acnt_q <= acnt_q + 2'd1;
            if (acnt_q == 2'd2) begin
              lock_sel_q <= addr_q[2]; // address bit 10 sits in the middle byte
              st_q <= rd_cmd ? ST_RDAT : ST_WDAT;
            end
          end
          ST_WDAT: if (byte_end) begin
            stage_we_q   <= 1'b1;
            stage_data_q <= rx_byte;
            have_dat_q   <= 1'b1;
          end
          ST_WAIT: extra_q <= 1'b1;
          default: ;
        endcase
      end
      if (act && sck_f && rd_st) begin
        tcnt_q <= tcnt_q + 3'd1;
        if (tcnt_q == 3'd0) begin
          tx_q <= nxt_byte;
          if (st_q == ST_RDAT && !(cmd_q == CM_RID && lock_sel_q)) addr_q <= addr_q + ONE_A;
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign miso_o        = tx_q[7];
  assign miso_oe_o     = act & rd_st;
  assign addr_o        = addr_q;
  assign id_sel_o      = (cmd_q == CM_RID) || (cmd_q == CM_WID);
  assign stage_we_o    = stage_we_q;
  assign stage_data_o  = stage_data_q;
  assign wen_set_o     = wen_set_q;
  assign wen_clr_o     = wen_clr_q;
  assign commit_o      = commit_q;
  assign commit_kind_o = kind_q;
endmodule

// File: rtl/spi_mem_fe_chk.sv
module spi_mem_fe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic miso_oe_o,
  input logic stage_we_o,
  input logic wen_set_o,
  input logic wen_clr_o,
  input logic commit_o
);
  // R6
  commit_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> cs_ni);
  // R6
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R2
  strobe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wen_set_o, wen_clr_o, commit_o}));
  // R7
  oe_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miso_oe_o) |-> !cs_ni);
  // R5
  stage_not_reading_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_we_o |-> !miso_oe_o);
endmodule

bind spi_mem_fe spi_mem_fe_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_oe_o (miso_oe_o),
  .stage_we_o(stage_we_o),
  .wen_set_o (wen_set_o),
  .wen_clr_o (wen_clr_o),
  .commit_o  (commit_o)
);

// File: tb/sim_spi_mem_fe.sv
`timescale 1ns/1ps
module sim_spi_mem_fe;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, mosi = 1'b0, hold = 1'b1, busy = 1'b0, lock = 1'b0;
  logic [7:0] status = 8'hC3;
  logic miso, oe, id_sel, stage_we, wen_set, wen_clr, commit;
  logic [18:0] addr;
  logic [7:0] rdata, stage_d;
  logic [1:0] kind;
  logic mode3 = 1'b0;

  int n_chk = 0, n_bad = 0, n_set = 0, n_clr = 0, n_com = 0, n_stg = 0;
  logic [1:0] last_kind = '0;
  logic oe_seen = 1'b0;
  logic [7:0]  stg_d[32];
  logic [18:0] stg_a[32];

  always #4 clk = ~clk;

  function automatic logic [7:0] model(input logic [18:0] a, input logic id);
    return id ? ~a[7:0] : (a[7:0] ^ {5'b0, a[18:16]});
  endfunction
  assign rdata = model(addr, id_sel);

  spi_mem_fe u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs), .sck_i(sck), .mosi_i(mosi), .hold_ni(hold),
    .miso_o(miso), .miso_oe_o(oe), .busy_i(busy), .status_i(status), .lock_i(lock),
    .addr_o(addr), .id_sel_o(id_sel), .rdata_i(rdata), .stage_we_o(stage_we),
    .stage_data_o(stage_d), .wen_set_o(wen_set), .wen_clr_o(wen_clr),
    .commit_o(commit), .commit_kind_o(kind)
  );

  always @(negedge clk) if (rst_n) begin
    if (wen_set) n_set++;
    if (wen_clr) n_clr++;
    if (commit) begin n_com++; last_kind = kind; end
    if (stage_we) begin
      if (n_stg < 32) begin stg_d[n_stg] = stage_d; stg_a[n_stg] = addr; end
      n_stg++;
    end
    if (oe) oe_seen = 1'b1;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    sck = 1'b0; mosi = b; wt(H);
    sck = 1'b1; r = miso; wt(H);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic q;
      sbit(t[i], q);
      r[i] = q;
    end
  endtask

  task automatic sel_on(); sck = mode3; wt(H); cs = 1'b0; wt(H); endtask
  task automatic sel_off(); if (!mode3) sck = 1'b0; wt(H); cs = 1'b1; wt(4*H); endtask
  task automatic put(input logic [7:0] t); logic [7:0] r; xfer(t, r); endtask
  task automatic put_addr(input logic [23:0] a); put(a[23:16]); put(a[15:8]); put(a[7:0]); endtask

  task automatic t_reset();
    int s0;
    chk("R1 oe after reset", oe, 0);
    s0 = n_set;
    put(8'h06); sck = 1'b0; wt(H); cs = 1'b1; wt(4*H);
    chk("R1 no command before first select fall", n_set - s0, 0);
    chk("R1 no commit", n_com, 0);
  endtask

  task automatic t_wen();
    int s0, c0;
    s0 = n_set; c0 = n_clr;
    sel_on(); put(8'h06); sel_off();
    chk("R2 write enable set", n_set - s0, 1);
    sel_on(); put(8'h04); sel_off();
    chk("R2 write enable clear", n_clr - c0, 1);
    sel_on(); put(8'h06);
    begin logic q; sbit(1'b0, q); sbit(1'b0, q); end
    sel_off();
    chk("R2 extra clocks cancel", n_set - s0, 1);
  endtask

  task automatic t_read(input logic m3, input logic [23:0] a, input int nb);
    logic [7:0] r;
    logic [18:0] x;
    mode3 = m3; x = a[18:0];
    sel_on(); put(8'h03); put_addr(a);
    for (int i = 0; i < nb; i++) begin
      xfer(8'h00, r);
      chk(m3 ? "R4 mode3 read" : "R3 read wrap", r, model(x, 1'b0));
      x = x + 19'd1;
    end
    sel_off(); mode3 = 1'b0;
  endtask

  task automatic t_write();
    int g0, c0;
    logic [18:0] ea[4];
    logic [7:0] ed[4];
    ea = '{19'h0123E, 19'h0123F, 19'h01230, 19'h01231};
    ed = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    g0 = n_stg; c0 = n_com;
    sel_on(); put(8'h02); put_addr(24'h00123E);
    for (int i = 0; i < 4; i++) put(ed[i]);
    sel_off();
    chk("R5 stage count", n_stg - g0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 stage data", stg_d[g0+i], ed[i]);
      chk("R5 stage page wrap addr", stg_a[g0+i], ea[i]);
    end
    chk("R6 commit on boundary", n_com - c0, 1);
    chk("R12 array kind", last_kind, 0);
  endtask

  task automatic t_discard();
    int c0;
    c0 = n_com;
    sel_on(); put(8'h02); put_addr(24'h000040); put(8'h11);
    begin logic q; sbit(1'b1, q); sbit(1'b0, q); sbit(1'b1, q); end
    sel_off();
    chk("R6 off-boundary discard", n_com - c0, 0);
    sel_on(); put(8'h02); put_addr(24'h000040); sel_off();
    chk("R6 no data byte discard", n_com - c0, 0);
  endtask

  task automatic t_bad();
    int s0, c0;
    s0 = n_set; c0 = n_com; oe_seen = 1'b0;
    sel_on(); put(8'hA5); put(8'h06); put(8'h03); put(8'h00); sel_off();
    chk("R7 parked no strobe", n_set - s0, 0);
    chk("R7 parked no commit", n_com - c0, 0);
    chk("R7 parked output off", oe_seen, 0);
  endtask

  task automatic t_busy();
    int c0;
    logic [7:0] r;
    busy = 1'b1; c0 = n_com; oe_seen = 1'b0;
    sel_on(); put(8'h03); put_addr(24'h000010); put(8'h00); sel_off();
    chk("R10 read rejected busy", oe_seen, 0);
    sel_on(); put(8'h02); put_addr(24'h000010); put(8'h55); sel_off();
    chk("R10 write rejected busy", n_com - c0, 0);
    sel_on(); put(8'h05);
    xfer(8'h00, r); chk("R10 status byte 1", r, status);
    xfer(8'h00, r); chk("R10 status byte 2", r, status);
    sel_off();
    busy = 1'b0;
  endtask

  task automatic t_id();
    logic [7:0] r;
    sel_on(); put(8'h83); put_addr(24'h000005);
    xfer(8'h00, r); chk("R11 id read byte 1", r, 8'hFA);
    xfer(8'h00, r); chk("R11 id read byte 2", r, 8'hF9);
    chk("R11 id select", id_sel, 1);
    sel_off();
    lock = 1'b1;
    sel_on(); put(8'h83); put_addr(24'h000400);
    xfer(8'h00, r); chk("R11 lock byte 1", r, 8'h01);
    xfer(8'h00, r); chk("R11 lock byte 2", r, 8'h01);
    sel_off();
    lock = 1'b0;
  endtask

  task automatic t_kinds();
    int c0, g0;
    c0 = n_com; g0 = n_stg;
    sel_on(); put(8'h01); put(8'h8C); sel_off();
    chk("R12 status kind", last_kind, 1);
    chk("R12 status data", stg_d[g0], 8'h8C);
    sel_on(); put(8'h82); put_addr(24'h000010); put(8'h3E); sel_off();
    chk("R12 id kind", last_kind, 2);
    sel_on(); put(8'h82); put_addr(24'h000400); put(8'h01); sel_off();
    chk("R12 lock kind", last_kind, 3);
    chk("R12 commit count", n_com - c0, 3);
  endtask

  task automatic t_hold();
    int c0, g0;
    logic [7:0] r;
    sel_on(); put(8'h05);
    sck = 1'b0; wt(H);
    chk("R8 output on before hold", oe, 1);
    hold = 1'b0; wt(H);
    chk("R8 output off in hold", oe, 0);
    repeat (2) begin sck = 1'b1; wt(H); sck = 1'b0; wt(H); end
    hold = 1'b1; wt(H);
    chk("R8 output back after hold", oe, 1);
    xfer(8'h00, r); chk("R8 status after hold", r, status);
    sel_off();
    c0 = n_com; g0 = n_stg;
    sel_on(); put(8'h02); put_addr(24'h000020);
    sck = 1'b0; wt(H); hold = 1'b0; wt(H); mosi = 1'b1;
    repeat (2) begin sck = 1'b1; wt(H); sck = 1'b0; wt(H); end
    hold = 1'b1; wt(H);
    put(8'h5C); sel_off();
    chk("R8 staged byte intact", stg_d[g0], 8'h5C);
    chk("R8 commit after hold", n_com - c0, 1);
  endtask

  task automatic t_hold_desel();
    int s0, c0;
    s0 = n_set; c0 = n_com;
    sel_on(); put(8'h05); sck = 1'b0; wt(H);
    hold = 1'b0; wt(H); cs = 1'b1; wt(4*H); hold = 1'b1; wt(H);
    chk("R9 output off after deselect", oe, 0);
    sel_on(); put(8'h06); sel_off();
    chk("R9 next command decodes", n_set - s0, 1);
    chk("R9 no commit", n_com - c0, 0);
  endtask

  initial begin
    wt(10); rst_n = 1'b1; wt(10);
    t_reset();
    t_wen();
    t_read(1'b0, 24'hFFFFFE, 3);
    t_read(1'b1, 24'h012345, 2);
    t_write();
    t_discard();
    t_bad();
    t_busy();
    t_id();
    t_kinds();
    t_hold();
    t_hold_desel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule